// File: doc/BRIEF.md
# Multi-Mode Fixed-Point Adder/Subtractor

This block adds or subtracts two signed two's-complement fractions of parameterised width W and returns the result under one of four policies for overflow and word growth. The operands lie in the range -1 ≤ x < 1, with the binary point just after the sign bit. The policy input picks one of four behaviours. Saturating clamps to the range limits. Wrap-around keeps the low W bits. Scaling always halves the result into W bits, or keeps all W+1 bits. Block-floating-point halves the result only when the sum would not fit.

A rounding control applies to every policy that drops a least-significant bit. With rounding on, the dropped bit is resolved by round-half-to-even. With rounding off, the dropped bit is truncated. A length control chooses between a W-bit result and a full W+1-bit result. The length control only has an effect in the scaling and block-floating-point policies. The result is registered once. Two flags come with it: one marks a true sum that does not fit in W bits, and one marks that the block-floating-point policy applied its halving shift.

Top module: `fxa_addsub`

## Requirements
- R1: The exact sum is op_a + op_b when do_sub is 0 and op_a - op_b when do_sub is 1, with both operands read as signed W-bit fractions. This exact sum is held in W+1 bits, and its top bit is the carry.
- R2: With policy 2'b00 (saturate), the result is the low W bits of the exact sum when that sum fits. When it does not fit, the result is the most positive value 0111..1 or the most negative value 1000..0, following the sign of the exact sum. Rounding is not used in this policy.
- R3: With policy 2'b01 (wrap), the result is the exact sum taken modulo 2^W, with no clamping and no rounding.
- R4: With policy 2'b10 (scale) and long_out = 1, the result is all W+1 bits of the exact sum.
- R5: With policy 2'b10 (scale) and long_out = 0, the result is always the exact sum shifted right by one, which is bits W down to 1. With rounding off, the dropped bit is discarded.
- R6: When round_en = 1 and a shift drops a 1, the kept value is incremented only if its LSB is 1 (half to even). An increment that would pass the most positive W-bit value yields that value instead.
- R7: With policy 2'b11 (block floating point) and long_out = 0, the result is the unshifted low W bits of the exact sum when the sum fits. When it does not fit, the result is the shifted value as in R5/R6 and shift_flag is 1. shift_flag is 0 in every other case.
- R8: With policy 2'b11 and long_out = 1, the result equals the full W+1-bit exact sum. long_out has no effect under policies 2'b00 and 2'b01. Every W-bit result is sign-extended to W+1 bits on the res port.
- R9: ovf_flag is 1 exactly when the exact sum lies outside the W-bit range, under every policy.
- R10: Outputs update one clock after the inputs are presented. A synchronous active-low reset clears res, ovf_flag and shift_flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | W | First operand, signed fraction |
| op_b | input | W | Second operand, signed fraction |
| do_sub | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| policy | input | 2 | 00 saturate, 01 wrap, 10 scale, 11 block floating point |
| round_en | input | 1 | 1 selects round-half-to-even on a dropped bit, 0 selects truncation |
| long_out | input | 1 | 1 selects a W+1-bit result under the scale and block-floating-point policies |
| res | output | W+1 | Result, with W-bit results sign-extended |
| ovf_flag | output | 1 | Exact sum does not fit in W bits |
| shift_flag | output | 1 | Block-floating-point halving was applied |

## Verification
The bench sweeps every operand pair of a 4-bit configuration through every policy, direction, rounding and length setting. It compares each result against an integer model built from the requirements. The sweep reaches the subtraction of the most negative value, where a design that negates the subtrahend in W bits would produce a wrong sign and a wrong overflow flag. It also reaches the maximum-minus-minimum case, where half-to-even rounding would carry past the positive limit; without the clamp the result would wrap to a negative value. Other targets are sums of exactly half an LSB with even and odd kept bits, which show rounding that is biased or inverted. The last is a non-overflowing sum under block floating point, which shows a shift or flag that fires without cause.

// File: rtl/fxa_pkg.sv
// Package fxa_pkg
// Shared encodings for the multi-mode fixed-point adder/subtractor.
// Assumes the policy input is two bits wide and carries these codes.
package fxa_pkg;

    typedef enum logic [1:0] {
        POL_SAT   = 2'b00,
        POL_WRAP  = 2'b01,
        POL_SCALE = 2'b10,
        POL_BFP   = 2'b11
    } fxa_policy_e;

endpackage

// File: rtl/fxa_sum_unit.sv
// Module fxa_sum_unit
// Forms the exact W+1-bit sum or difference of two signed W-bit operands
// and reports whether that exact value fits back into W bits.
// Assumes two's-complement operands; the W+1-bit width makes even
// a - (most negative) exact, so no negation overflow can occur.
module fxa_sum_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         sub_in,
    output logic [W:0]   sum_full,
    output logic         no_fit
);

    localparam int EW = W + 1;

    logic [EW-1:0] a_ext;
    logic [EW-1:0] b_ext;
    logic [EW-1:0] b_eff;
    logic [EW-1:0] cin_vec;

    // Sign-extend both operands and build the conditionally inverted subtrahend.
    always_comb begin
        a_ext   = {a_in[W-1], a_in};
        b_ext   = {b_in[W-1], b_in};
        b_eff   = sub_in ? ~b_ext : b_ext;
        cin_vec = {{(EW-1){1'b0}}, sub_in};
    end

    // Exact sum; the carry-in completes the two's-complement negation.
    always_comb begin
        sum_full = a_ext + b_eff + cin_vec;
        no_fit   = sum_full[W] ^ sum_full[W-1];
    end

endmodule

// File: rtl/fxa_halve_round.sv
// Module fxa_halve_round
// Shifts the exact W+1-bit sum right by one into W bits and resolves the
// dropped bit by truncation or by round-half-to-even. An increment that
// would pass the most positive value is held at that value.
// Assumes the input is the exact sum from fxa_sum_unit.
module fxa_halve_round #(
    parameter int W = 16
) (
    input  logic [W:0]   sum_full,
    input  logic         round_en,
    output logic [W-1:0] halved
);

    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] kept;
    logic         drop_bit;
    logic         bump;

    // Split the sum into the kept upper bits and the dropped LSB.
    always_comb begin
        kept     = sum_full[W:1];
        drop_bit = sum_full[0];
        bump     = round_en & drop_bit & kept[0];
    end

    // Apply the even-rounding increment, clamping at the positive limit.
    always_comb begin
        if (!bump) begin
            halved = kept;
        end else if (kept == POS_MAX) begin
            halved = POS_MAX;
        end else begin
            halved = kept + {{(W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/fxa_policy_mux.sv
// Module fxa_policy_mux
// Chooses the final W+1-bit result and the shift flag from the exact sum,
// its overflow indication and the halved value, following the policy and
// the output-length select. W-bit results are sign-extended.
module fxa_policy_mux #(
    parameter int W = 16
) (
    input  fxa_pkg::fxa_policy_e policy,
    input  logic                 long_out,
    input  logic [W:0]           sum_full,
    input  logic                 no_fit,
    input  logic [W-1:0]         halved,
    output logic [W:0]           res_next,
    output logic                 shift_next
);

    import fxa_pkg::*;

    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] clamped;
    logic [W-1:0] low_bits;
    logic [W-1:0] narrow;
    logic         use_long;

    // Saturated candidate: exact low bits, or the limit named by the carry.
    always_comb begin
        low_bits = sum_full[W-1:0];
        if (no_fit) begin
            clamped = sum_full[W] ? NEG_MIN : POS_MAX;
        end else begin
            clamped = low_bits;
        end
    end

    // Pick the W-bit candidate and the shift flag for each policy.
    always_comb begin
        narrow     = low_bits;
        shift_next = 1'b0;
        use_long   = 1'b0;
        unique case (policy)
            POL_SAT: begin
                narrow = clamped;
            end
            POL_WRAP: begin
                narrow = low_bits;
            end
            POL_SCALE: begin
                narrow   = halved;
                use_long = long_out;
            end
            POL_BFP: begin
                narrow     = no_fit ? halved : low_bits;
                shift_next = no_fit & ~long_out;
                use_long   = long_out;
            end
            default: begin
                narrow = low_bits;
            end
        endcase
    end

    // Full-precision result or a sign-extended W-bit result.
    always_comb begin
        res_next = use_long ? sum_full : {narrow[W-1], narrow};
    end

endmodule

// File: rtl/fxa_addsub.sv
// Module fxa_addsub (top)
// Multi-mode fixed-point adder/subtractor for signed W-bit fractions.
// Policies: saturate, wrap, scale, block floating point; optional
// round-half-to-even of a dropped LSB; W or W+1-bit output length.
// Assumes a single clock; REG_OUT=1 gives one cycle of latency with a
// synchronous active-low reset, REG_OUT=0 gives a purely combinational path.
module fxa_addsub #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         do_sub,
    input  logic [1:0]   policy,
    input  logic         round_en,
    input  logic         long_out,
    output logic [W:0]   res,
    output logic         ovf_flag,
    output logic         shift_flag
);

    import fxa_pkg::*;

    logic [W:0]   sum_full;
    logic         no_fit;
    logic [W-1:0] halved;
    logic [W:0]   res_next;
    logic         shift_next;
    fxa_policy_e  pol_sel;

    // Interpret the raw policy code as the shared enumeration.
    always_comb begin
        pol_sel = fxa_policy_e'(policy);
    end

    fxa_sum_unit #(.W(W)) u_sum (
        .a_in     (op_a),
        .b_in     (op_b),
        .sub_in   (do_sub),
        .sum_full (sum_full),
        .no_fit   (no_fit)
    );

    fxa_halve_round #(.W(W)) u_half (
        .sum_full (sum_full),
        .round_en (round_en),
        .halved   (halved)
    );

    fxa_policy_mux #(.W(W)) u_mux (
        .policy     (pol_sel),
        .long_out   (long_out),
        .sum_full   (sum_full),
        .no_fit     (no_fit),
        .halved     (halved),
        .res_next   (res_next),
        .shift_next (shift_next)
    );

    generate
        if (REG_OUT) begin : g_reg
            // Output register with synchronous active-low clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res        <= '0;
                    ovf_flag   <= 1'b0;
                    shift_flag <= 1'b0;
                end else begin
                    res        <= res_next;
                    ovf_flag   <= no_fit;
                    shift_flag <= shift_next;
                end
            end
        end else begin : g_comb
            // Direct combinational outputs.
            always_comb begin
                res        = res_next;
                ovf_flag   = no_fit;
                shift_flag = shift_next;
            end
        end
    endgenerate

endmodule

// File: rtl/fxa_addsub_chk.sv
// Module fxa_addsub_chk
// Checker for the registered configuration of fxa_addsub: relates each
// registered output to the inputs of the previous cycle.
module fxa_addsub_chk #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         do_sub,
    input logic [1:0]   policy,
    input logic         long_out,
    input logic [W:0]   res,
    input logic         ovf_flag,
    input logic         shift_flag
);

    localparam logic [1:0] C_SAT   = 2'b00;
    localparam logic [1:0] C_WRAP  = 2'b01;
    localparam logic [1:0] C_SCALE = 2'b10;
    localparam logic [1:0] C_BFP   = 2'b11;
    localparam logic [W:0] R_MAX   = {2'b00, {(W-1){1'b1}}};
    localparam logic [W:0] R_MIN   = {2'b11, {(W-1){1'b0}}};

    logic [W-1:0] low_ref;

    // Modulo-2^W reference of the previous inputs for comparison.
    always_ff @(posedge clk) begin
        low_ref <= do_sub ? (op_a - op_b) : (op_a + op_b);
    end

    generate
        if (REG_OUT) begin : g_props
            AST_RST_CLEAR: assert property (@(posedge clk)
                !rst_n |=> (res == '0 && !ovf_flag && !shift_flag)); // R10

            AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(policy) == C_SAT && ovf_flag)
                    |-> (res == R_MAX || res == R_MIN)); // R2

            AST_WRAP_MODULO: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(policy) == C_WRAP) |-> (res[W-1:0] == low_ref)); // R3

            AST_SHIFT_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
                shift_flag |-> ovf_flag); // R7

            AST_SHIFT_ONLY_BFP: assert property (@(posedge clk) disable iff (!rst_n)
                shift_flag |-> ($past(policy) == C_BFP && !$past(long_out))); // R7

            AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !($past(long_out) && ($past(policy) == C_SCALE || $past(policy) == C_BFP)))
                    |-> (res[W] == res[W-1])); // R8

            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !ovf_flag && $past(policy) != C_SCALE)
                    |-> (res[W-1:0] == low_ref)); // R9
        end
    endgenerate

endmodule

bind fxa_addsub fxa_addsub_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_b       (op_b),
    .do_sub     (do_sub),
    .policy     (policy),
    .long_out   (long_out),
    .res        (res),
    .ovf_flag   (ovf_flag),
    .shift_flag (shift_flag)
);

// File: tb/fxa_addsub_test.sv
module fxa_addsub_test;

    localparam int W    = 4;
    localparam int PMAX = (1 << (W - 1)) - 1;
    localparam int PMIN = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         do_sub = 1'b0;
    logic [1:0]   policy = 2'b00;
    logic         round_en = 1'b0;
    logic         long_out = 1'b0;
    logic [W:0]   res;
    logic         ovf_flag;
    logic         shift_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fxa_addsub #(.W(W), .REG_OUT(1'b1)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_a       (op_a),
        .op_b       (op_b),
        .do_sub     (do_sub),
        .policy     (policy),
        .round_en   (round_en),
        .long_out   (long_out),
        .res        (res),
        .ovf_flag   (ovf_flag),
        .shift_flag (shift_flag)
    );

    function automatic int halve(input int s, input bit rnd);
        int h;
        h = s >>> 1;
        if (rnd && (s & 1) != 0 && (h & 1) != 0) h = h + 1;
        if (h > PMAX) h = PMAX;
        return h;
    endfunction

    function automatic string tag_of(input int pol, input bit rnd, input bit lng);
        if (pol == 0) return lng ? "R8" : "R2";
        if (pol == 1) return lng ? "R8" : "R3";
        if (pol == 2) return lng ? "R4" : (rnd ? "R6" : "R5");
        return lng ? "R8" : "R7";
    endfunction

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one vector and check outputs one clock later.
    task automatic run_vec(input int a, input int b, input bit sb, input int pol,
                           input bit rnd, input bit lng, input string tag_over);
        int s, e, r;
        bit ov, sh;
        string tg;
        @(negedge clk);
        op_a = a[W-1:0];
        op_b = b[W-1:0];
        do_sub = sb;
        policy = pol[1:0];
        round_en = rnd;
        long_out = lng;
        s = sb ? a - b : a + b;
        ov = (s > PMAX) || (s < PMIN);
        sh = 1'b0;
        r = s & ((1 << W) - 1);
        if (r > PMAX) r = r - (1 << W);
        case (pol)
            0: e = ov ? (s > 0 ? PMAX : PMIN) : s;
            1: e = r;
            2: e = lng ? s : halve(s, rnd);
            default: begin
                if (lng) e = s;
                else if (ov) begin e = halve(s, rnd); sh = 1'b1; end
                else e = s;
            end
        endcase
        tg = (tag_over.len() != 0) ? tag_over : tag_of(pol, rnd, lng);
        @(negedge clk);
        check_int(tg, $signed(res), e);
        check_int("R9", int'(ovf_flag), int'(ov));
        check_int("R7", int'(shift_flag), int'(sh));
    endtask

    initial begin
        // R10: reset state.
        repeat (3) @(negedge clk);
        check_int("R10", int'(res), 0);
        check_int("R10", int'(ovf_flag), 0);
        check_int("R10", int'(shift_flag), 0);
        rst_n = 1'b1;

        // R1: plain sum and difference: 0.25+0.25 and 0.25-(-0.5).
        run_vec(2, 2, 1'b0, 1, 1'b0, 1'b0, "R1");
        run_vec(2, -4, 1'b1, 1, 1'b0, 1'b0, "R1");
        // R6: max minus min, half-even increment would pass the limit.
        run_vec(PMAX, PMIN, 1'b1, 2, 1'b1, 1'b0, "R6");
        // R6: exact half with even kept LSB stays put: 1+0 -> 0.
        run_vec(1, 0, 1'b0, 2, 1'b1, 1'b0, "R6");
        // R7: BFP overflow with rounding: 7+6=13 -> 6 (half, kept even).
        run_vec(7, 6, 1'b0, 3, 1'b1, 1'b0, "R7");

        // Exhaustive sweep of the 4-bit configuration.
        for (int pol = 0; pol < 4; pol++) begin
            for (int cfg = 0; cfg < 8; cfg++) begin
                for (int a = PMIN; a <= PMAX; a++) begin
                    for (int b = PMIN; b <= PMAX; b++) begin
                        run_vec(a, b, cfg[0], pol, cfg[1], cfg[2], "");
                    end
                end
            end
        end

        // R10: reset clears outputs after a non-zero result.
        run_vec(PMAX, PMAX, 1'b0, 2, 1'b0, 1'b1, "R4");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_int("R10", int'(res), 0);
        check_int("R10", int'(ovf_flag), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule